// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a two-wire serial slave that lets a host read and write a small bank of configuration bytes, for example clock-output enable bits. The bus pads are open-drain. The block takes SCL and SDA in from the pads and pulls SDA low through an output-enable. All register contents are presented in parallel to the rest of the chip. Every register loads a fixed default at reset, so the chip works with no serial traffic at all.

The host selects one of two access styles through bit 7 of the command byte. With bit 7 set, bits 6:0 index a single register for a byte read or a byte write. With bit 7 clear, the access is sequential. It begins at register 0 and steps up one register per byte. The host may stop it after any whole byte. In the sequential style a byte-count phase follows the command. A configuration input removes that phase, for hosts that issue plain block transfers.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, register n of `regs_o` (bits 8n+7:8n) holds 8'hF0+n, and `sda_oe_o` is low.
- R2: The slave acknowledges a first byte of D2h (write) or D3h (read), which is 7-bit address 0x69. It does not acknowledge any other first byte. After a non-matching address it keeps SDA released and ignores all traffic until the next start condition.
- R3: Byte write is start, D2h, command with bit 7 = 1 and bits 6:0 = offset, one data byte, stop. It replaces register `offset` and leaves all other registers unchanged. The slave acknowledges every byte.
- R4: Byte read is start, D2h, command with bit 7 = 1 and offset, repeated start, D3h, then one byte from the slave. That byte equals register `offset` and is sent most significant bit first.
- R5: With `skip_count_i` = 0, a block write is start, D2h, command 00h, then a count byte. The count byte is acknowledged and does not change any register. Each following data byte goes to registers 0, 1, 2 and so on.
- R6: With `skip_count_i` = 1, a block write has no count phase. The first byte after the command goes to register 0.
- R7: Block read is start, D2h, command 00h, repeated start, D3h. With `skip_count_i` = 0 the slave first sends a count byte of 8, then registers 0 upward. With `skip_count_i` = 1 it sends register 0 first.
- R8: A block write ended by a stop after k complete data bytes (k < 8) updates exactly registers 0 to k-1. The other registers keep their previous values.
- R9: In a block write, data bytes beyond register 7 are acknowledged and change no register.
- R10: When the host answers a transmitted byte with NACK, the slave releases SDA and drives nothing more until a stop or a start condition.
- R11: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| skip_count_i | input | 1 | 1 = sequential transfers carry no byte-count phase |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| regs_o | output | 64 | Register bank, register n at bits 8n+7:8n |

## Verification
The bench builds the block with its defaults: 8 registers and address 0x69. At that size every register offset can be written and read back individually. Block writes of every length from 0 to 10 bytes can be run in both count modes, so each early-stop point and the overflow past the last register are all covered. Several wrong addresses, the register walk of a full block read, and a host NACK in the middle of a read are also covered.

// File: rtl/smb_cfg_pkg.sv
// Shared types for the two-wire configuration slave.
package smb_cfg_pkg;
    // link-layer phase of the protocol engine
    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_WAIT
    } link_st_t;

    // meaning of the byte currently being received
    typedef enum logic [1:0] {
        RX_ADDR, RX_CMD, RX_CNT, RX_DATA
    } rx_kind_t;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = 7;   // width of the command offset field
endpackage

// File: rtl/smb_pad_sync.sv
// Pad synchronizer and bus-event detector.
// Brings SCL and SDA through SYNC_STAGES flops, then flags SCL edges and
// start (SDA falls while SCL high) / stop (SDA rises while SCL high).
// Assumes the system clock is several times faster than SCL.
module smb_pad_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] scl_pipe;
    logic [PIPE_W-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    // shift pad levels through the synchronizer chain; idle bus is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_i};
            sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_i};
        end
    end

    assign scl_s    = scl_pipe[SYNC_STAGES-1];
    assign sda_s    = sda_pipe[SYNC_STAGES-1];
    assign scl_prev = scl_pipe[SYNC_STAGES];
    assign sda_prev = sda_pipe[SYNC_STAGES];

    // edge and bus-condition decode on the synchronized levels
    always_comb begin
        scl_rise  = scl_s & ~scl_prev;
        scl_fall  = ~scl_s & scl_prev;
        start_det = scl_s & scl_prev & sda_prev & ~sda_s;
        stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
    end
endmodule

// File: rtl/smb_cfg_bank.sv
// Configuration register bank.
// Holds NUM_REGS bytes loaded from DEFAULTS at reset, takes one byte write
// per cycle from the protocol engine and offers a combinational read port.
// Read of an index past the bank returns zero.
module smb_cfg_bank
    import smb_cfg_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter logic [NUM_REGS*BYTE_W-1:0] DEFAULTS = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [PTR_W-1:0]           wr_idx,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [PTR_W-1:0]           rd_idx,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [NUM_REGS*BYTE_W-1:0] bank_o
);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_REGS - 1);

    logic [NUM_REGS*BYTE_W-1:0] bank_q;

    // load defaults at reset, else update the addressed byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= DEFAULTS;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_idx == PTR_W'(i)) bank_q[i*BYTE_W +: BYTE_W] <= wr_data;
            end
        end
    end

    // read multiplexer
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == PTR_W'(i)) rd_data = bank_q[i*BYTE_W +: BYTE_W];
        end
    end

    assign bank_o = bank_q;

    // R9
    wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx <= LAST_IDX));
endmodule

// File: rtl/smb_link_fsm.sv
// Protocol engine of the two-wire slave.
// Receives address, command, count and data bytes on SCL rising edges,
// drives acknowledge and read data after SCL falling edges. Start and stop
// conditions override any phase. Assumes synchronized inputs from
// smb_pad_sync and a bank of NUM_REGS bytes behind rd_/wr_ ports.
module smb_link_fsm
    import smb_cfg_pkg::*;
#(
    parameter int              NUM_REGS = 8,
    parameter logic [6:0]      DEV_ADDR = 7'h69
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              skip_count,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [PTR_W-1:0]  rd_idx,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_oe
);
    localparam logic [PTR_W-1:0]  LAST_IDX   = PTR_W'(NUM_REGS - 1);
    localparam logic [PTR_W-1:0]  PTR_MAX    = '1;
    localparam logic [BYTE_W-1:0] COUNT_BYTE = BYTE_W'(NUM_REGS);
    localparam logic [3:0]        BITS_DONE  = 4'd8;

    link_st_t          state;
    rx_kind_t          kind;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [PTR_W-1:0]  ptr;
    logic              blk_mode;
    logic              to_tx;
    logic              cnt_pend;
    logic              mack_nack;
    logic [BYTE_W-1:0] tx_byte;

    // next byte to transmit: pending count, else the addressed register
    assign tx_byte = cnt_pend ? COUNT_BYTE : rd_data;
    assign rd_idx  = ptr;

    // protocol sequencing, one transition per synchronized bus event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            kind      <= RX_ADDR;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            ptr       <= '0;
            blk_mode  <= 1'b0;
            to_tx     <= 1'b0;
            cnt_pend  <= 1'b0;
            mack_nack <= 1'b0;
            sda_oe    <= 1'b0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state   <= ST_RX;
                kind    <= RX_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise && bit_cnt != BITS_DONE) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == BITS_DONE) begin
                            bit_cnt <= '0;
                            to_tx   <= 1'b0;
                            case (kind)
                                RX_ADDR: begin
                                    if (rx_sh[7:1] == DEV_ADDR) begin
                                        sda_oe <= 1'b1;
                                        state  <= ST_ACK;
                                        if (rx_sh[0]) begin
                                            to_tx    <= 1'b1;
                                            cnt_pend <= blk_mode & ~skip_count;
                                            if (blk_mode) ptr <= '0;
                                        end else begin
                                            kind <= RX_CMD;
                                        end
                                    end else begin
                                        state <= ST_WAIT;
                                    end
                                end
                                RX_CMD: begin
                                    blk_mode <= ~rx_sh[7];
                                    ptr      <= rx_sh[7] ? rx_sh[6:0] : '0;
                                    kind     <= (rx_sh[7] || skip_count) ? RX_DATA : RX_CNT;
                                    sda_oe   <= 1'b1;
                                    state    <= ST_ACK;
                                end
                                RX_CNT: begin
                                    kind   <= RX_DATA;
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                end
                                default: begin
                                    if (ptr <= LAST_IDX) wr_en <= 1'b1;
                                    wr_idx  <= ptr;
                                    wr_data <= rx_sh;
                                    if (ptr != PTR_MAX) ptr <= ptr + 1'b1;
                                    sda_oe  <= 1'b1;
                                    state   <= ST_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            if (to_tx) begin
                                tx_sh   <= {tx_byte[BYTE_W-2:0], 1'b0};
                                sda_oe  <= ~tx_byte[BYTE_W-1];
                                bit_cnt <= 4'd1;
                                if (cnt_pend) cnt_pend <= 1'b0;
                                else if (ptr != PTR_MAX) ptr <= ptr + 1'b1;
                                state   <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == BITS_DONE) begin
                                sda_oe <= 1'b0;
                                state  <= ST_MACK;
                            end else begin
                                sda_oe  <= ~tx_sh[BYTE_W-1];
                                tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack_nack <= sda_s;
                        end else if (scl_fall) begin
                            if (mack_nack) begin
                                state <= ST_WAIT;
                            end else begin
                                tx_sh   <= {tx_byte[BYTE_W-2:0], 1'b0};
                                sda_oe  <= ~tx_byte[BYTE_W-1];
                                bit_cnt <= 4'd1;
                                if (cnt_pend) cnt_pend <= 1'b0;
                                else if (ptr != PTR_MAX) ptr <= ptr + 1'b1;
                                state   <= ST_TX;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11
    oe_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));

    // R2
    oe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state == ST_ACK || state == ST_TX));

    // R2
    nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RX && kind == RX_ADDR && scl_fall && bit_cnt == BITS_DONE &&
         rx_sh[7:1] != DEV_ADDR && !start_det && !stop_det)
        |=> (state == ST_WAIT && !sda_oe));

    // R10
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MACK && mack_nack && scl_fall && !start_det && !stop_det)
        |=> (state == ST_WAIT && !sda_oe));
endmodule

// File: rtl/smb_cfg_slave.sv
// Top of the two-wire configuration slave.
// Connects pad synchronizer, protocol engine and register bank. SDA is
// open-drain: sda_oe_o = 1 pulls the pad low. Register contents appear in
// parallel on regs_o. Assumes clk is at least 8x the SCL rate.
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter int         NUM_REGS    = 8,
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         SYNC_STAGES = 2,
    parameter logic [NUM_REGS*BYTE_W-1:0] DEFAULTS = 64'hF7F6_F5F4_F3F2_F1F0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    input  logic                       skip_count_i,
    output logic                       sda_oe_o,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_idx, rd_idx;
    logic [BYTE_W-1:0] wr_data, rd_data;

    smb_pad_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_link_fsm #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .skip_count(skip_count_i),
        .rd_data(rd_data), .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .sda_oe(sda_oe_o)
    );

    smb_cfg_bank #(.NUM_REGS(NUM_REGS), .DEFAULTS(DEFAULTS)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .bank_o(regs_o)
    );
endmodule

// File: tb/sim_smb_cfg_slave.sv
// Bench: bit-level bus master sweeping offsets, lengths and modes.
module sim_smb_cfg_slave;
    localparam int Q = 5;   // clocks per quarter SCL period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        skip_m = 1'b0;
    logic        sda_oe_o;
    logic [63:0] regs_o;
    wire         sda_bus = sda_m & ~sda_oe_o;

    int          n_tests = 0;
    int          n_fail  = 0;
    int          oe_high_changes = 0;
    logic [7:0]  model [8];

    always #10 clk = ~clk;

    smb_cfg_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .skip_count_i(skip_m), .sda_oe_o(sda_oe_o), .regs_o(regs_o)
    );

    // R11 monitor: the output-enable must not move while SCL is high
    always @(sda_oe_o) if (rst_n && scl_m) oe_high_changes++;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_bus; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        acked = ~b;
    endtask

    task automatic recv_byte(input logic host_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~host_ack);
    endtask

    task automatic chk_bank(input string tag);
        for (int i = 0; i < 8; i++) chk(tag, {24'd0, regs_o[i*8 +: 8]}, {24'd0, model[i]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic       ak;
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: defaults 8'hF0+n, SDA released
        for (int i = 0; i < 8; i++) model[i] = 8'hF0 + 8'(i);
        chk_bank("R1 default");
        chk("R1 oe", {31'd0, sda_oe_o}, 32'd0);

        // R3 / R4: byte write then byte read at every offset
        for (int off = 0; off < 8; off++) begin
            logic [7:0] val;
            val = 8'h3C ^ 8'(off * 29);
            bus_start();
            send_byte(8'hD2, ak); chk("R2 write address ack", {31'd0, ak}, 32'd1);
            send_byte(8'h80 | 8'(off), ak); chk("R3 command ack", {31'd0, ak}, 32'd1);
            send_byte(val, ak); chk("R3 data ack", {31'd0, ak}, 32'd1);
            bus_stop();
            model[off] = val;
            chk_bank("R3 byte write");
            bus_start();
            send_byte(8'hD2, ak);
            send_byte(8'h80 | 8'(off), ak);
            bus_start();
            send_byte(8'hD3, ak); chk("R2 read address ack", {31'd0, ak}, 32'd1);
            recv_byte(1'b0, v); chk("R4 byte read", {24'd0, v}, {24'd0, val});
            bus_stop();
        end

        // R2: foreign addresses get no ack and no effect
        for (int a = 0; a < 6; a++) begin
            logic [7:0] adr;
            adr = (a == 0) ? 8'hD0 : (a == 1) ? 8'hD4 : (a == 2) ? 8'h52 :
                  (a == 3) ? 8'hD6 : (a == 4) ? 8'hC2 : 8'h93;
            bus_start();
            send_byte(adr, ak); chk("R2 foreign address nack", {31'd0, ak}, 32'd0);
            send_byte(8'h80, ak); chk("R2 ignored byte nack", {31'd0, ak}, 32'd0);
            send_byte(8'h00, ak); chk("R2 ignored data nack", {31'd0, ak}, 32'd0);
            bus_stop();
            chk_bank("R2 bank untouched");
        end

        // R5 / R6 / R8 / R9: block writes of every length in both modes
        for (int mode = 0; mode < 2; mode++) begin
            skip_m = mode[0];
            for (int n = 0; n <= 10; n++) begin
                bus_start();
                send_byte(8'hD2, ak);
                send_byte(8'h00, ak);
                if (mode == 0) begin
                    send_byte(8'(n), ak); chk("R5 count ack", {31'd0, ak}, 32'd1);
                end
                for (int k = 0; k < n; k++) begin
                    logic [7:0] d;
                    d = 8'(n * 16 + k * 7 + mode * 85);
                    send_byte(d, ak);
                    chk(k < 8 ? (mode == 0 ? "R5 data ack" : "R6 data ack") : "R9 overflow ack",
                        {31'd0, ak}, 32'd1);
                    if (k < 8) model[k] = d;
                end
                bus_stop();
                chk_bank(n < 8 ? "R8 early stop" : (mode == 0 ? "R5 r9_ full block" : "R6 r9_ full block"));
            end
        end

        // R7: block read with and without count phase
        for (int mode = 0; mode < 2; mode++) begin
            skip_m = mode[0];
            bus_start();
            send_byte(8'hD2, ak);
            send_byte(8'h00, ak);
            bus_start();
            send_byte(8'hD3, ak); chk("R7 read address ack", {31'd0, ak}, 32'd1);
            if (mode == 0) begin
                recv_byte(1'b1, v); chk("R7 count byte", {24'd0, v}, 32'd8);
            end
            for (int k = 0; k < 8; k++) begin
                recv_byte(k != 7, v); chk("R7 block data", {24'd0, v}, {24'd0, model[k]});
            end
            bus_stop();
        end

        // R10: host NACK ends transmission; bus stays released
        bus_start();
        send_byte(8'hD2, ak);
        send_byte(8'h82, ak);
        bus_start();
        send_byte(8'hD3, ak);
        recv_byte(1'b0, v); chk("R10 byte before nack", {24'd0, v}, {24'd0, model[2]});
        recv_byte(1'b0, v); chk("R10 released after nack", {24'd0, v}, 32'hFF);
        bus_stop();
        skip_m = 1'b1;
        bus_start();
        send_byte(8'hD2, ak);
        send_byte(8'h00, ak);
        bus_start();
        send_byte(8'hD3, ak);
        recv_byte(1'b1, v); chk("R10 block first", {24'd0, v}, {24'd0, model[0]});
        recv_byte(1'b0, v); chk("R10 block second", {24'd0, v}, {24'd0, model[1]});
        recv_byte(1'b1, v); chk("R10 block released", {24'd0, v}, 32'hFF);
        bus_stop();
        chk("R10 oe idle", {31'd0, sda_oe_o}, 32'd0);

        // R11: SDA enable never moved while SCL high
        chk("R11 oe change while scl high", oe_high_changes, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule